// File: doc/BRIEF.md
# Command/Data Register Access Port

This block is the slave side of a parallel microcontroller bus. Its job is to reach a small set of configuration registers. One address line splits every bus write into one of two kinds. With the line high, the write is a command: the low byte names an operation. With the line low, the access is a data phase that moves bytes or words to or from the register that the last command selected.

Registers wider than the bus take several data phases, least significant part first. A command that needs no data acts at the moment it is written. A separate resume input write-protects the registers. They stay protected until a fixed key is written through the unlock command.

The bus runs eight or sixteen bits wide, chosen by a mode input. In sixteen-bit mode every access is a whole word. Bits that carry no meaning are dropped.

The control sequencer has four states:
- `ST_IDLE`: no transfer is pending.
- `ST_WRITE`: write data phases are expected.
- `ST_READ`: read data phases are expected.
- `ST_UNLOCK`: key phases are expected.

Its transitions are:
- `T_START`: a recognised command moves from any state into the state for its kind.
- `T_DROP`: an unknown command, or the fire command, returns to `ST_IDLE` from any state.
- `T_STEP`: a data phase of the matching direction uses one phase and stays in the state.
- `T_LAST`: the final expected phase returns to `ST_IDLE`.

Top module: `cmdif_top`

## Requirements
- R1: A write strobe with `bus_a0`=1 is a command phase. Only `bus_wdata[7:0]` is taken as the code, and `bus_wdata[15:8]` has no effect. A new command abandons any transfer still pending.
- R2: Codes 0x20+n (n = 0..15) take one data write phase into configuration byte n. The byte is `bus_wdata[7:0]` in both modes, and the upper byte is ignored.
- R3: Codes 0x30+n take one data read phase from configuration byte n. `bus_rdata` holds {8'h00, byte} from the clock edge that samples the read strobe.
- R4: Code 0xB8 writes and code 0xB9 reads a 16-bit mode word. With `wide_mode`=0 this takes two byte phases, low byte first, and each byte is stored as its phase arrives. With `wide_mode`=1 it takes one word phase.
- R5: A data phase with no transfer pending, or after the command's phase count is used up, changes no register. A read in that situation returns 0. A read strobe with `bus_a0`=1 also returns 0.
- R6: Any code not listed in R2, R3, R4, R7 or R9 is discarded. It changes no register, produces no pulse, and leaves the sequencer idle.
- R7: Code 0xF4 has no data phase. `exec_pulse` is high for exactly the one cycle after the edge that samples the command.
- R8: A `resume_evt` pulse sets write protection. While protection is set, writes to configuration bytes and to the mode word are ignored, and reads still work.
- R9: Code 0xB0 takes a 16-bit key: two byte phases low byte first in 8-bit mode, one word in 16-bit mode. Key 0xAA37 clears protection and any other key leaves it set. If `resume_evt` arrives in the same cycle as the final key phase, protection stays set.
- R10: After reset all configuration bytes and the mode word are 0, protection is clear, the sequencer is idle, and `bus_rdata` and `exec_pulse` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wide_mode | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| bus_a0 | input | 1 | 1 = command phase, 0 = data phase |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access (ignored while `bus_wr` is high) |
| bus_wdata | input | 16 | Write data; only [7:0] carries meaning in 8-bit mode |
| bus_rdata | output | 16 | Registered read data |
| resume_evt | input | 1 | Resume indication, sets write protection |
| exec_pulse | output | 1 | One-cycle pulse from the data-less command |

## Verification
The hardest case to reach from the ports is a resume that lands in exactly the same cycle as the final key phase of a correct unlock. The bench drives that case by hand: it issues the unlock command, then raises `resume_evt` together with the data strobe carrying 0xAA37. It then shows, through a configuration write and a readback, that protection still holds. A second hard case is a data phase following each of the roughly 220 undefined codes. This is covered by a sweep over all 256 codes that skips the defined ones, followed by a full readback.

// File: rtl/cmdif_pkg.sv
package cmdif_pkg;

    localparam int IDX_W      = 4;
    localparam int MODE_BYTES = 2;

    localparam logic [7:0] CMD_CFG_WR  = 8'h20;
    localparam logic [7:0] CMD_CFG_RD  = 8'h30;
    localparam logic [7:0] CMD_UNLOCK  = 8'hB0;
    localparam logic [7:0] CMD_MODE_WR = 8'hB8;
    localparam logic [7:0] CMD_MODE_RD = 8'hB9;
    localparam logic [7:0] CMD_FIRE    = 8'hF4;

    typedef enum logic [2:0] {
        OP_BAD,
        OP_CFG_WR,
        OP_CFG_RD,
        OP_MODE_WR,
        OP_MODE_RD,
        OP_UNLOCK,
        OP_FIRE
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WRITE,
        ST_READ,
        ST_UNLOCK
    } state_e;

    typedef struct packed {
        op_e              op;
        logic [IDX_W-1:0] idx;
        logic [1:0]       phases;
    } dec_t;

endpackage

// File: rtl/cmdif_decode.sv
module cmdif_decode
    import cmdif_pkg::*;
#(
    parameter int NUM_CFG = 16
) (
    input  logic [7:0] code,
    input  logic       wide,
    output dec_t       dec
);

    localparam logic [1:0] WORD_PHASES_W = 2'(MODE_BYTES / 2);
    localparam logic [1:0] WORD_PHASES_N = 2'(MODE_BYTES);

    logic in_range;
    logic [1:0] word_phases;

    assign in_range    = int'(code[3:0]) < NUM_CFG;
    assign word_phases = wide ? WORD_PHASES_W : WORD_PHASES_N;

    always_comb begin
        dec = '{op: OP_BAD, idx: code[IDX_W-1:0], phases: 2'd0};
        if (code[7:4] == CMD_CFG_WR[7:4] && in_range) begin
            dec.op     = OP_CFG_WR;
            dec.phases = 2'd1;
        end else if (code[7:4] == CMD_CFG_RD[7:4] && in_range) begin
            dec.op     = OP_CFG_RD;
            dec.phases = 2'd1;
        end else if (code == CMD_MODE_WR) begin
            dec.op     = OP_MODE_WR;
            dec.phases = word_phases;
        end else if (code == CMD_MODE_RD) begin
            dec.op     = OP_MODE_RD;
            dec.phases = word_phases;
        end else if (code == CMD_UNLOCK) begin
            dec.op     = OP_UNLOCK;
            dec.phases = word_phases;
        end else if (code == CMD_FIRE) begin
            dec.op     = OP_FIRE;
        end
    end

endmodule

// File: rtl/cmdif_regs.sv
module cmdif_regs
    import cmdif_pkg::*;
#(
    parameter int          NUM_CFG    = 16,
    parameter logic [15:0] UNLOCK_KEY = 16'hAA37
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  resume_evt,
    input  logic                  cfg_we,
    input  logic [IDX_W-1:0]      cfg_widx,
    input  logic [7:0]            cfg_wbyte,
    input  logic [IDX_W-1:0]      cfg_ridx,
    output logic [7:0]            cfg_rbyte,
    input  logic [MODE_BYTES-1:0] mode_we,
    input  logic [8*MODE_BYTES-1:0] mode_wdata,
    output logic [8*MODE_BYTES-1:0] mode_word,
    input  logic                  key_try,
    input  logic [15:0]           key_word,
    output logic                  locked
);

    logic [7:0]         cfg_q [NUM_CFG];
    logic [NUM_CFG-1:0] rd_sel;
    logic               locked_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_CFG; i++) cfg_q[i] <= '0;
        end else if (cfg_we && !locked_q) begin
            for (int i = 0; i < NUM_CFG; i++)
                if (cfg_widx == IDX_W'(i)) cfg_q[i] <= cfg_wbyte;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_word <= '0;
        end else if (!locked_q) begin
            for (int b = 0; b < MODE_BYTES; b++)
                if (mode_we[b]) mode_word[8*b +: 8] <= mode_wdata[8*b +: 8];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                               locked_q <= 1'b0;
        else if (resume_evt)                      locked_q <= 1'b1;
        else if (key_try && key_word == UNLOCK_KEY) locked_q <= 1'b0;
    end

    for (genvar g = 0; g < NUM_CFG; g++) begin : g_rsel
        assign rd_sel[g] = (cfg_ridx == IDX_W'(g));
    end

    always_comb begin
        cfg_rbyte = '0;
        for (int i = 0; i < NUM_CFG; i++)
            if (rd_sel[i]) cfg_rbyte = cfg_q[i];
    end

    assign locked = locked_q;

endmodule

// File: rtl/cmdif_fsm.sv
module cmdif_fsm
    import cmdif_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wide,
    input  logic                    bus_a0,
    input  logic                    bus_wr,
    input  logic                    bus_rd,
    input  logic [15:0]             bus_wdata,
    input  dec_t                    dec,
    input  logic [7:0]              cfg_rbyte,
    input  logic [8*MODE_BYTES-1:0] mode_word,
    output state_e                  state,
    output logic [IDX_W-1:0]        idx,
    output logic                    cfg_we,
    output logic [7:0]              cfg_wbyte,
    output logic [MODE_BYTES-1:0]   mode_we,
    output logic [8*MODE_BYTES-1:0] mode_wdata,
    output logic                    key_try,
    output logic [15:0]             key_word,
    output logic [15:0]             bus_rdata,
    output logic                    exec_pulse
);

    state_e           state_q, state_d;
    op_e              op_q, op_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic [1:0]       left_q, left_d;
    logic             ptr_q, ptr_d;
    logic [7:0]       key_lo_q, key_lo_d;

    logic        cmd_hit, dat_wr, dat_rd, rd_any;
    logic [15:0] rd_value;

    assign cmd_hit = bus_wr && bus_a0;
    assign dat_wr  = bus_wr && !bus_a0;
    assign rd_any  = bus_rd && !bus_wr;
    assign dat_rd  = rd_any && !bus_a0;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            op_q     <= OP_BAD;
            idx_q    <= '0;
            left_q   <= '0;
            ptr_q    <= 1'b0;
            key_lo_q <= '0;
        end else begin
            state_q  <= state_d;
            op_q     <= op_d;
            idx_q    <= idx_d;
            left_q   <= left_d;
            ptr_q    <= ptr_d;
            key_lo_q <= key_lo_d;
        end
    end

    // Next state
    always_comb begin
        state_d  = state_q;
        op_d     = op_q;
        idx_d    = idx_q;
        left_d   = left_q;
        ptr_d    = ptr_q;
        key_lo_d = key_lo_q;
        if (cmd_hit) begin
            op_d   = dec.op;
            idx_d  = dec.idx;
            left_d = dec.phases;
            ptr_d  = 1'b0;
            unique case (dec.op)
                OP_CFG_WR, OP_MODE_WR: state_d = ST_WRITE;
                OP_CFG_RD, OP_MODE_RD: state_d = ST_READ;
                OP_UNLOCK:             state_d = ST_UNLOCK;
                default:               state_d = ST_IDLE;
            endcase
        end else begin
            unique case (state_q)
                ST_IDLE: ;
                ST_WRITE, ST_UNLOCK: begin
                    if (dat_wr) begin
                        left_d = left_q - 2'd1;
                        ptr_d  = 1'b1;
                        if (state_q == ST_UNLOCK) key_lo_d = bus_wdata[7:0];
                        if (left_q == 2'd1) state_d = ST_IDLE;
                    end
                end
                ST_READ: begin
                    if (dat_rd) begin
                        left_d = left_q - 2'd1;
                        ptr_d  = 1'b1;
                        if (left_q == 2'd1) state_d = ST_IDLE;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        cfg_we     = 1'b0;
        cfg_wbyte  = bus_wdata[7:0];
        mode_we    = '0;
        mode_wdata = wide ? bus_wdata : {bus_wdata[7:0], bus_wdata[7:0]};
        key_try    = 1'b0;
        key_word   = wide ? bus_wdata : {bus_wdata[7:0], key_lo_q};
        rd_value   = '0;
        if (!cmd_hit && dat_wr) begin
            unique case (state_q)
                ST_WRITE: begin
                    if (op_q == OP_CFG_WR) cfg_we = 1'b1;
                    else if (wide)         mode_we = '1;
                    else                   mode_we = ptr_q ? 2'b10 : 2'b01;
                end
                ST_UNLOCK: key_try = (left_q == 2'd1);
                default: ;
            endcase
        end
        if (dat_rd && state_q == ST_READ) begin
            if (op_q == OP_CFG_RD)  rd_value = {8'h00, cfg_rbyte};
            else if (wide)          rd_value = mode_word;
            else                    rd_value = {8'h00, ptr_q ? mode_word[15:8] : mode_word[7:0]};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata  <= '0;
            exec_pulse <= 1'b0;
        end else begin
            exec_pulse <= cmd_hit && dec.op == OP_FIRE;
            if (rd_any) bus_rdata <= rd_value;
        end
    end

    assign state = state_q;
    assign idx   = idx_q;

endmodule

// File: rtl/cmdif_top.sv
module cmdif_top
    import cmdif_pkg::*;
#(
    parameter int          NUM_CFG    = 16,
    parameter logic [15:0] UNLOCK_KEY = 16'hAA37
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wide_mode,
    input  logic        bus_a0,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    input  logic        resume_evt,
    output logic        exec_pulse
);

    dec_t                    dec;
    state_e                  fsm_state;
    logic [IDX_W-1:0]        sel_idx;
    logic                    cfg_we;
    logic [7:0]              cfg_wbyte, cfg_rbyte;
    logic [MODE_BYTES-1:0]   mode_we;
    logic [8*MODE_BYTES-1:0] mode_wdata, mode_word;
    logic                    key_try, locked;
    logic [15:0]             key_word;

    cmdif_decode #(.NUM_CFG(NUM_CFG)) u_dec (
        .code (bus_wdata[7:0]),
        .wide (wide_mode),
        .dec  (dec)
    );

    cmdif_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wide       (wide_mode),
        .bus_a0     (bus_a0),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_wdata  (bus_wdata),
        .dec        (dec),
        .cfg_rbyte  (cfg_rbyte),
        .mode_word  (mode_word),
        .state      (fsm_state),
        .idx        (sel_idx),
        .cfg_we     (cfg_we),
        .cfg_wbyte  (cfg_wbyte),
        .mode_we    (mode_we),
        .mode_wdata (mode_wdata),
        .key_try    (key_try),
        .key_word   (key_word),
        .bus_rdata  (bus_rdata),
        .exec_pulse (exec_pulse)
    );

    cmdif_regs #(.NUM_CFG(NUM_CFG), .UNLOCK_KEY(UNLOCK_KEY)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .resume_evt (resume_evt),
        .cfg_we     (cfg_we),
        .cfg_widx   (sel_idx),
        .cfg_wbyte  (cfg_wbyte),
        .cfg_ridx   (sel_idx),
        .cfg_rbyte  (cfg_rbyte),
        .mode_we    (mode_we),
        .mode_wdata (mode_wdata),
        .mode_word  (mode_word),
        .key_try    (key_try),
        .key_word   (key_word),
        .locked     (locked)
    );

endmodule

// File: rtl/cmdif_chk.sv
module cmdif_chk
    import cmdif_pkg::*;
#(
    parameter int NUM_CFG = 16
) (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_a0,
    input logic        bus_wr,
    input logic        bus_rd,
    input logic [15:0] bus_wdata,
    input logic [15:0] bus_rdata,
    input logic        resume_evt,
    input logic        exec_pulse,
    input state_e      fsm_state,
    input logic        locked,
    input logic [15:0] mode_word
);

    logic [7:0] c;
    logic       known;
    assign c = bus_wdata[7:0];
    assign known = ((c[7:4] == 4'h2 || c[7:4] == 4'h3) && int'(c[3:0]) < NUM_CFG)
                 || c == 8'hB0 || c == 8'hB8 || c == 8'hB9 || c == 8'hF4;

    // R1: the upper byte does not disturb a configuration-write command
    p_cmd_low_byte_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_a0 && c == 8'h20) |=> fsm_state == ST_WRITE);

    // R5: a data read while idle returns zero
    p_idle_read_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && !bus_a0 && fsm_state == ST_IDLE) |=> bus_rdata == 16'h0000);

    // R6: an undefined code leaves the sequencer idle
    p_bad_code_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_a0 && !known) |=> fsm_state == ST_IDLE);

    // R7: the pulse only follows the fire command
    p_pulse_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        exec_pulse |-> $past(bus_wr && bus_a0 && bus_wdata[7:0] == 8'hF4));

    // R8: resume sets protection
    p_resume_locks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        resume_evt |=> locked);

    // R8: while protected the mode word cannot change
    p_lock_holds_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(locked) |-> $stable(mode_word));

endmodule

bind cmdif_top cmdif_chk #(.NUM_CFG(NUM_CFG)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_a0     (bus_a0),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .resume_evt (resume_evt),
    .exec_pulse (exec_pulse),
    .fsm_state  (fsm_state),
    .locked     (locked),
    .mode_word  (mode_word)
);

// File: tb/tb_cmdif_top.sv
module tb_cmdif_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wide_mode = 1'b0;
    logic        bus_a0 = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        resume_evt = 1'b0;
    logic        exec_pulse;

    int n_chk = 0;
    int n_err = 0;
    logic [7:0]  exp_cfg [16];
    logic [15:0] exp_mode;

    always #2 clk = ~clk;

    cmdif_top dut (
        .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .bus_a0(bus_a0),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .resume_evt(resume_evt), .exec_pulse(exec_pulse)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic put_cmd(input logic [15:0] w);
        @(negedge clk); bus_a0 = 1'b1; bus_wr = 1'b1; bus_wdata = w;
        @(negedge clk); bus_wr = 1'b0; bus_a0 = 1'b0;
    endtask

    task automatic put_dat(input logic [15:0] w);
        @(negedge clk); bus_a0 = 1'b0; bus_wr = 1'b1; bus_wdata = w;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic get_dat(output logic [15:0] r);
        @(negedge clk); bus_a0 = 1'b0; bus_rd = 1'b1;
        @(negedge clk); bus_rd = 1'b0; r = bus_rdata;
    endtask

    task automatic wr_cfg(input int n, input logic [7:0] v);
        put_cmd({8'h6C, 8'h20 + 8'(n)});
        put_dat({8'h9D, v});
    endtask

    task automatic rd_cfg(input int n, output logic [15:0] r);
        put_cmd({8'h00, 8'h30 + 8'(n)});
        get_dat(r);
    endtask

    task automatic wr_word(input logic [7:0] code, input logic [15:0] v);
        put_cmd({8'h00, code});
        if (wide_mode) put_dat(v);
        else begin put_dat({8'h5A, v[7:0]}); put_dat({8'hC3, v[15:8]}); end
    endtask

    task automatic rd_mode(output logic [15:0] r);
        logic [15:0] lo, hi;
        put_cmd(16'h00B9);
        if (wide_mode) get_dat(r);
        else begin
            get_dat(lo); get_dat(hi);
            check("R4 byte read upper zero", {lo[15:8], hi[15:8]}, 16'h0000);
            r = {hi[7:0], lo[7:0]};
        end
    endtask

    task automatic check_all(input string req);
        logic [15:0] r;
        for (int n = 0; n < 16; n++) begin
            rd_cfg(n, r);
            check(req, r, {8'h00, exp_cfg[n]});
        end
        rd_mode(r);
        check(req, r, exp_mode);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [15:0] r;
        int pulses;
        for (int n = 0; n < 16; n++) exp_cfg[n] = 8'h00;
        exp_mode = 16'h0000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state
        check("R10 rdata", bus_rdata, 16'h0000);
        check("R10 pulse", {15'd0, exec_pulse}, 16'h0000);
        check_all("R10 reset contents");

        // R2 R3 R4: full sweeps in both bus widths
        for (int w = 0; w < 2; w++) begin
            wide_mode = w[0];
            for (int n = 0; n < 16; n++) begin
                exp_cfg[n] = 8'((n * 37) + (w * 101) + 5);
                wr_cfg(n, exp_cfg[n]);
            end
            exp_mode = 16'h1234 ^ 16'(w * 16'h8181);
            wr_word(8'hB8, exp_mode);
            check_all("R2 R3 R4 sweep");
        end

        // R1: junk upper byte on command, abort of a pending transfer
        wide_mode = 1'b0;
        put_cmd(16'hA521); put_dat(16'hFF4E); exp_cfg[1] = 8'h4E;
        rd_cfg(1, r); check("R1 upper byte ignored", r, 16'h004E);
        put_cmd(16'h00B8); put_dat(16'h0077); exp_mode[7:0] = 8'h77;
        rd_cfg(2, r); check("R1 abort then read", r, {8'h00, exp_cfg[2]});
        put_dat(16'h0099);
        rd_mode(r); check("R1 R4 abort keeps first byte only", r, exp_mode);

        // R5: surplus and idle phases
        wr_cfg(4, 8'hC4); exp_cfg[4] = 8'hC4;
        put_dat(16'h00EE);
        rd_cfg(4, r); check("R5 surplus write ignored", r, 16'h00C4);
        get_dat(r); check("R5 surplus read zero", r, 16'h0000);
        @(negedge clk); bus_a0 = 1'b1; bus_rd = 1'b1;
        @(negedge clk); bus_rd = 1'b0; bus_a0 = 1'b0;
        check("R5 read in command phase zero", bus_rdata, 16'h0000);

        // R6: every undefined code
        pulses = 0;
        for (int c = 0; c < 256; c++) begin
            if (c[7:4] == 4'h2 || c[7:4] == 4'h3 || c == 8'hB0 || c == 8'hB8 ||
                c == 8'hB9 || c == 8'hF4) continue;
            put_cmd({8'h00, 8'(c)});
            if (exec_pulse) pulses++;
            put_dat(16'hFFFF);
            if (c % 16 == 0) begin
                get_dat(r); check("R6 read after bad code", r, 16'h0000);
            end
        end
        check("R6 no pulse", 16'(pulses), 16'h0000);
        check_all("R6 contents after bad codes");

        // R7: fire command
        put_cmd(16'h33F4);
        check("R7 pulse high", {15'd0, exec_pulse}, 16'h0001);
        @(negedge clk);
        check("R7 pulse single", {15'd0, exec_pulse}, 16'h0000);

        // R8 R9: protection in 8-bit mode
        @(negedge clk); resume_evt = 1'b1; @(negedge clk); resume_evt = 1'b0;
        wr_cfg(3, 8'h3E); wr_word(8'hB8, 16'hDEAD);
        check_all("R8 writes blocked");
        wr_word(8'hB0, 16'hAA38);
        wr_cfg(3, 8'h3E);
        check_all("R9 wrong key keeps lock");
        wr_word(8'hB0, 16'hAA37);
        wr_cfg(3, 8'h3E); exp_cfg[3] = 8'h3E;
        check_all("R9 narrow unlock");

        // R9: resume in the same cycle as the final key word, 16-bit mode
        wide_mode = 1'b1;
        put_cmd(16'h00B0);
        @(negedge clk); bus_wr = 1'b1; bus_wdata = 16'hAA37; resume_evt = 1'b1;
        @(negedge clk); bus_wr = 1'b0; resume_evt = 1'b0;
        wr_cfg(5, 8'h55);
        check_all("R9 resume wins");
        wr_word(8'hB0, 16'hAA37);
        wr_cfg(5, 8'h55); exp_cfg[5] = 8'h55;
        exp_mode = 16'hBEEF; wr_word(8'hB8, exp_mode);
        check_all("R9 wide unlock");

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule